// File: doc/BRIEF.md
# Vectored IRQ/FIQ Interrupt Controller

This block gathers a set of level-sensitive interrupt lines, organised as banks of 32, and turns them into two processor requests. The normal request (`irq_o`) is raised by any unmasked pending source. The fast request (`fiq_o`) is raised only by unmasked pending sources that software has steered to the fast path through a per-source select bit. A priority encoder picks the lowest-numbered unmasked pending source and gives its number times four as a vector. Software reads this vector and uses it directly as a table offset.

Software reaches the controller through a plain word-wide register port. Writes take effect at the rising clock edge. Reads are combinational from the current address. Each line is sampled into its pending bit on every clock edge. The request outputs and the vector are combinational from the registered state, so they follow a source one cycle after it changes. A sticky fast-pending record captures every source that has raised a fast request, and software clears it by writing ones. The enable registers are stored and read back only; they do not gate either request. Addresses that decode to no register read as zero, and writes to them have no effect.

Register map (byte offsets, bank `b` at `+4*b`): vector 0x00, base address 0x04, protect 0x08, NMI control 0x0C, pending 0x10, fast-pending 0x20, select 0x30, enable 0x40, mask 0x50.

Top module: `vic_ctrl`

## Requirements
- R1: On every rising edge, bit k of pending bank b takes the level of source 32*b+k. The bank is readable at offset 0x10+4*b.
- R2: `irq_o` is high exactly when some source is both pending and not masked, in any bank.
- R3: `fiq_o` is high exactly when some source is pending, not masked and has its select bit set.
- R4: Offset 0x00 reads (32*b + k)*4, where b is the lowest bank with an unmasked pending bit and k is the lowest such bit in that bank. It reads 0 when no such bit exists.
- R5: Writes to the pending offsets 0x10..0x18 change nothing.
- R6: A fast-pending bit (offset 0x20+4*b) is set on each edge where its source is pending, unmasked and selected. It stays set until software writes a 1 to it. A write of 0 leaves it unchanged, and a set in the same cycle wins over a clear.
- R7: The base address (0x04) stores the written word with bits [1:0] forced to 0. The protect (0x08) and NMI control (0x0C) registers store and return the full word.
- R8: Select (0x30+4*b), enable (0x40+4*b) and mask (0x50+4*b) store and return the full word. A mask bit of 1 blocks its source. Enable has no effect on `irq_o`, `fiq_o` or the vector.
- R9: Reset clears the base address, protect, NMI control, pending, fast-pending, select, enable and mask registers. After reset the vector reads 0 and both requests are low.
- R10: A read from an undecoded offset (for example 0x1C, 0x60, 0x3FC, or any offset with bits [1:0] not zero) returns 0. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_lines | input | 96 | Level-sensitive interrupt sources, source n on bit n |
| reg_wr | input | 1 | Register write strobe, one word per cycle |
| reg_addr | input | 10 | Byte offset for register read or write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that `irq_lines`, `reg_wr`, `reg_addr` and `reg_wdata` are settled at each rising edge, and that a write strobe is a single-cycle event carrying a decoded or undecoded offset. The bench changes every input only on the falling edge. It samples outputs a short time after that falling edge, once the state captured at the previous rising edge has propagated through the encoder. It keeps the mask and select settings fixed while it walks the vector table, so each row depends only on its own source pattern.

// File: rtl/vic_pkg.sv
package vic_pkg;
  // register groups selected by offset bits above the bank field
  typedef enum logic [2:0] {
    GRP_NONE  = 3'd0,
    GRP_PEND  = 3'd1,
    GRP_FPEND = 3'd2,
    GRP_SEL   = 3'd3,
    GRP_EN    = 3'd4,
    GRP_MASK  = 3'd5
  } grp_e;

  // scalar word indices inside the first 16-byte row
  localparam int unsigned SCL_VEC  = 0;
  localparam int unsigned SCL_BASE = 1;
  localparam int unsigned SCL_PROT = 2;
  localparam int unsigned SCL_NMI  = 3;

  // map offset bits [.:4] (row number) to a group
  function automatic grp_e row_to_grp(input int unsigned row);
    case (row)
      1:       return GRP_PEND;
      2:       return GRP_FPEND;
      3:       return GRP_SEL;
      4:       return GRP_EN;
      5:       return GRP_MASK;
      default: return GRP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vic_bank.sv
module vic_bank
  import vic_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] src,
  input  logic          wr_en,
  input  grp_e          wr_grp,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] pend_o,
  output logic [DW-1:0] fpend_o,
  output logic [DW-1:0] sel_o,
  output logic [DW-1:0] en_o,
  output logic [DW-1:0] mask_o,
  output logic [DW-1:0] act_o,
  output logic [DW-1:0] fact_o
);
  logic [DW-1:0] pend_q, fpend_q, sel_q, en_q, mask_q;
  logic [DW-1:0] live, fast_live;

  assign live      = pend_q & ~mask_q;
  assign fast_live = live & sel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q  <= '0;
      fpend_q <= '0;
      sel_q   <= '0;
      en_q    <= '0;
      mask_q  <= '0;
    end else begin
      pend_q <= src;  // pending writes are dropped
      if (wr_en && wr_grp == GRP_FPEND) fpend_q <= (fpend_q & ~wdata) | fast_live;
      else                              fpend_q <= fpend_q | fast_live;
      if (wr_en && wr_grp == GRP_SEL)  sel_q  <= wdata;
      if (wr_en && wr_grp == GRP_EN)   en_q   <= wdata;
      if (wr_en && wr_grp == GRP_MASK) mask_q <= wdata;
    end
  end

  assign pend_o  = pend_q;
  assign fpend_o = fpend_q;
  assign sel_o   = sel_q;
  assign en_o    = en_q;
  assign mask_o  = mask_q;
  assign act_o   = live;
  assign fact_o  = fast_live;

  // R1, R5: pending follows the line, whatever was written
  assert_pend_tracks_src_R1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> pend_q == $past(src));

  // R6: without a clearing write no fast-pending bit drops
  assert_fpend_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_grp == GRP_FPEND) |=> ((fpend_q & $past(fpend_q)) == $past(fpend_q)));
endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned N     = 96,
  parameter int unsigned IDX_W = $clog2(N)
) (
  input  logic [N-1:0]     act,
  output logic             found,
  output logic [IDX_W-1:0] idx
);
  // lowest index wins: bank order first, then bit order inside the bank
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (act[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/vic_ctrl.sv
module vic_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 3,
  parameter int unsigned DW        = 32,
  parameter int unsigned ADDR_W    = 10
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_BANKS*DW-1:0] irq_lines,
  input  logic                    reg_wr,
  input  logic [ADDR_W-1:0]       reg_addr,
  input  logic [DW-1:0]           reg_wdata,
  output logic [DW-1:0]           reg_rdata,
  output logic                    irq_o,
  output logic                    fiq_o
);
  localparam int unsigned NUM_SRC = NUM_BANKS * DW;
  localparam int unsigned IDX_W   = $clog2(NUM_SRC);

  logic [NUM_SRC-1:0] pend_all, fpend_all, sel_all, en_all, mask_all, act_all, fact_all;
  logic               any_found;
  logic [IDX_W-1:0]   win_idx;
  logic [DW-1:0]      vec_word;
  logic [DW-1:0]      base_q, prot_q, nmi_q;

  // offset decode: word aligned, bank field in bits [3:2], row above it
  logic        aligned;
  logic [1:0]  slot;
  int unsigned row;
  grp_e        grp;
  logic        bank_ok;

  assign aligned = (reg_addr[1:0] == 2'b00);
  assign slot    = reg_addr[3:2];
  assign row     = int'(reg_addr[ADDR_W-1:4]);
  assign grp     = row_to_grp(row);
  assign bank_ok = (int'(slot) < NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = reg_wr && aligned && (grp != GRP_NONE) && (int'(slot) == b);
    vic_bank #(.DW(DW)) bank_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .src     (irq_lines[b*DW +: DW]),
      .wr_en   (bank_wr),
      .wr_grp  (grp),
      .wdata   (reg_wdata),
      .pend_o  (pend_all[b*DW +: DW]),
      .fpend_o (fpend_all[b*DW +: DW]),
      .sel_o   (sel_all[b*DW +: DW]),
      .en_o    (en_all[b*DW +: DW]),
      .mask_o  (mask_all[b*DW +: DW]),
      .act_o   (act_all[b*DW +: DW]),
      .fact_o  (fact_all[b*DW +: DW])
    );
  end

  vic_prio #(.N(NUM_SRC), .IDX_W(IDX_W)) prio_i (
    .act   (act_all),
    .found (any_found),
    .idx   (win_idx)
  );

  always_comb begin
    vec_word = '0;
    if (any_found) vec_word[IDX_W+1:0] = {win_idx, 2'b00};
  end

  assign irq_o = |act_all;
  assign fiq_o = |fact_all;

  // scalar registers in the first row
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      prot_q <= '0;
      nmi_q  <= '0;
    end else if (reg_wr && aligned && row == 0) begin
      case (int'(slot))
        SCL_BASE: base_q <= {reg_wdata[DW-1:2], 2'b00};
        SCL_PROT: prot_q <= reg_wdata;
        SCL_NMI:  nmi_q  <= reg_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (aligned) begin
      if (row == 0) begin
        case (int'(slot))
          SCL_VEC:  reg_rdata = vec_word;
          SCL_BASE: reg_rdata = base_q;
          SCL_PROT: reg_rdata = prot_q;
          SCL_NMI:  reg_rdata = nmi_q;
          default:  reg_rdata = '0;
        endcase
      end else if (bank_ok) begin
        case (grp)
          GRP_PEND:  reg_rdata = pend_all[int'(slot)*DW +: DW];
          GRP_FPEND: reg_rdata = fpend_all[int'(slot)*DW +: DW];
          GRP_SEL:   reg_rdata = sel_all[int'(slot)*DW +: DW];
          GRP_EN:    reg_rdata = en_all[int'(slot)*DW +: DW];
          GRP_MASK:  reg_rdata = mask_all[int'(slot)*DW +: DW];
          default:   reg_rdata = '0;
        endcase
      end
    end
  end

  // R3: a fast request is always also a normal request
  assert_fiq_implies_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fiq_o |-> irq_o);

  // R4: a nonzero vector needs an active normal request
  assert_vector_needs_irq_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_word != '0) |-> irq_o);
endmodule

// File: tb/vic_ctrl_tb.sv
`timescale 1ns/1ps
module vic_ctrl_tb_top;
  localparam int NB = 3;
  localparam int DW = 32;
  localparam int NS = NB * DW;
  localparam int ROWS = 10;

  // row: {sources, irq, fiq, vector}; mask bank0 = 0xF0, select src32 and src95
  localparam logic [NS+33:0] TBL [ROWS] = '{
    {96'h00000000_00000000_00000000, 1'b0, 1'b0, 32'd0},
    {96'h00000000_00000000_00000001, 1'b1, 1'b0, 32'd0},
    {96'h00000000_00000000_00000020, 1'b0, 1'b0, 32'd0},
    {96'h00000000_00000000_00000220, 1'b1, 1'b0, 32'd36},
    {96'h00000000_00000001_00000000, 1'b1, 1'b1, 32'd128},
    {96'h00000000_00000101_00000000, 1'b1, 1'b1, 32'd128},
    {96'h80000000_00000000_00000000, 1'b1, 1'b1, 32'd380},
    {96'h80000001_00000000_00000040, 1'b1, 1'b1, 32'd256},
    {96'h00000040_00000002_00000000, 1'b1, 1'b0, 32'd132},
    {96'h00000000_80000000_00000010, 1'b1, 1'b0, 32'd252}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NS-1:0] lines = '0;
  logic          wr = 1'b0;
  logic [9:0]    addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic          irq, fiq;
  int            total = 0;
  int            bad = 0;

  always #2 clk = ~clk;

  vic_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .irq_lines(lines), .reg_wr(wr),
    .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata),
    .irq_o(irq), .fiq_o(fiq)
  );

  task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", what, got, exp);
    end
  endtask

  task automatic wr_reg(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_chk(input string what, input logic [9:0] a, input logic [31:0] exp);
    addr = a;
    #0.5;
    chk(what, rdata, exp);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog got=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    rd_chk("R9 vector", 10'h000, 0);
    rd_chk("R9 base", 10'h004, 0);
    rd_chk("R9 mask b2", 10'h058, 0);
    rd_chk("R9 select b0", 10'h030, 0);
    chk("R9 irq", {31'd0, irq}, 0);
    rst_n = 1'b1;

    // R7: scalar registers
    wr_reg(10'h004, 32'h1234_5677);
    rd_chk("R7 base low bits", 10'h004, 32'h1234_5674);
    wr_reg(10'h008, 32'hA5A5_0003);
    rd_chk("R7 protect", 10'h008, 32'hA5A5_0003);
    wr_reg(10'h00C, 32'h0000_00FF);
    rd_chk("R7 nmi", 10'h00C, 32'h0000_00FF);

    // R8: configuration for the table
    wr_reg(10'h050, 32'h0000_00F0);
    wr_reg(10'h034, 32'h0000_0001);
    wr_reg(10'h038, 32'h8000_0000);
    rd_chk("R8 mask b0", 10'h050, 32'h0000_00F0);
    rd_chk("R8 select b2", 10'h038, 32'h8000_0000);

    // R2 R3 R4: vector table walk
    for (int i = 0; i < ROWS; i++) begin
      @(negedge clk);
      lines = TBL[i][NS+33:34];
      @(negedge clk);
      rd_chk($sformatf("R4 vector row %0d", i), 10'h000, TBL[i][31:0]);
      chk($sformatf("R2 irq row %0d", i), {31'd0, irq}, {31'd0, TBL[i][33]});
      chk($sformatf("R3 fiq row %0d", i), {31'd0, fiq}, {31'd0, TBL[i][32]});
    end

    // R1 R5: pending follows lines, writes dropped
    @(negedge clk);
    lines = 96'h00000000_00000000_00000008;
    wr_reg(10'h010, 32'hFFFF_FFFF);
    rd_chk("R5 pending b0 after write", 10'h010, 32'h0000_0008);
    rd_chk("R1 pending b1", 10'h014, 32'h0);
    lines = 96'h00000004_00000000_00000000;
    @(negedge clk);
    rd_chk("R1 pending b2", 10'h018, 32'h0000_0004);

    // R8: enable does not gate requests
    wr_reg(10'h048, 32'h0);
    chk("R8 irq with enable clear", {31'd0, irq}, 1);
    wr_reg(10'h040, 32'hDEAD_BEEF);
    rd_chk("R8 enable b0", 10'h040, 32'hDEAD_BEEF);

    // R6: fast-pending sticky and write-one-to-clear
    lines = '0;
    wr_reg(10'h024, 32'hFFFF_FFFF);
    wr_reg(10'h028, 32'hFFFF_FFFF);
    rd_chk("R6 cleared b1", 10'h024, 32'h0);
    lines = 96'h00000000_00000001_00000000;
    @(negedge clk);
    @(negedge clk);
    lines = '0;
    @(negedge clk);
    @(negedge clk);
    rd_chk("R6 sticky b1", 10'h024, 32'h0000_0001);
    chk("R6 fiq low after line drop", {31'd0, fiq}, 0);
    wr_reg(10'h024, 32'hFFFF_FFFE);
    rd_chk("R6 write zero keeps", 10'h024, 32'h0000_0001);
    wr_reg(10'h024, 32'h0000_0001);
    rd_chk("R6 write one clears", 10'h024, 32'h0);
    rd_chk("R6 unselected b0", 10'h020, 32'h0);

    // R10: undecoded offsets
    wr_reg(10'h05C, 32'hFFFF_FFFF);
    wr_reg(10'h051, 32'hFFFF_FFFF);
    wr_reg(10'h060, 32'hFFFF_FFFF);
    rd_chk("R10 mask b0 unchanged", 10'h050, 32'h0000_00F0);
    rd_chk("R10 read 0x1C", 10'h01C, 32'h0);
    rd_chk("R10 read 0x3FC", 10'h3FC, 32'h0);
    rd_chk("R10 misaligned read", 10'h005, 32'h0);

    // R9: reset again clears configuration
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    rd_chk("R9 mask after reset", 10'h050, 32'h0);
    rd_chk("R9 base after reset", 10'h004, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule